// File: doc/BRIEF.md
# Prescaled Multi-Channel Interval Timer Unit

This block groups between one and eight countdown timer channels behind one register window and drives them all from a shared 16-bit prescaler. The prescaler is a down-counter that wraps every R+1 system clocks, where R is its programmable reload value. At each wrap it sends a single-cycle tick to every channel. Each channel counts its own 32-bit counter down once per tick while enabled. When the counter is zero on a tick, the channel underflows. It can then raise a one-cycle interrupt on its own line, latch a sticky pending flag, and either reload and carry on or stop.

Software reaches the unit through a single-cycle word bus. Only the low eight address bits are decoded. Word 0 of the unit window is the live prescaler count, word 1 is the prescaler reload, and word 2 is a read-only capability word. Channel n has its own 16-byte window at offset 0x10*(n+1), holding its counter, its reload value and its control word. Read data comes back one clock after the read request and holds until the next read.

Top module: `ttu_top`

## Requirements
- R1: After reset the prescaler count and the prescaler reload are 0. Every channel's counter, reload and control word read as 0, and no interrupt line is high.
- R2: When the prescaler count is 0 it reloads from the prescaler reload register and emits a tick. Otherwise it decrements by one each clock. With reload R the count therefore cycles R, R-1, ..., 0, giving one tick every R+1 clocks, and R=0 gives a tick every clock.
- R3: A write to the unit's word 1 (offset 0x04) changes only the reload register. The running prescaler period finishes at its old length. A write to word 0 (offset 0x00) loads the prescaler count directly with the low 16 bits of the write data.
- R4: Unit word 2 (offset 0x08) reads as a fixed capability word, and writes to it are ignored. Its fields are: bits [2:0] hold the number of timers minus one, bits [7:3] hold the base interrupt line, bit 8 is 1 (one interrupt line per timer) and bit 9 is 1 (freeze unsupported). With the defaults of 2 timers and base line 8, the word is 0x341.
- R5: Channel n is at 0x10*(n+1). Its counter is at +0x0, its reload at +0x4 and its control word at +0x8, and each of them reads back what was stored.
- R6: An enabled channel (control bit 0) decrements its counter once per prescaler tick. A tick while the counter is 0 is an underflow, so a counter started at N underflows on the (N+1)-th tick.
- R7: On an underflow with interrupt enable (control bit 3) set, the channel's irq line is high for exactly one clock and pending (control bit 4) becomes 1. Writing a control word with bit 4 set clears pending. Writing one with bit 4 clear leaves pending unchanged.
- R8: On an underflow with restart (control bit 1) set, the counter reloads from the channel's reload register and keeps running. With restart clear, the counter stays at 0 and the enable bit is cleared.
- R9: A control write with load (control bit 2) set copies the channel's reload value into its counter. Load always reads as 0.
- R10: The following accesses are unmapped: offset +0xC in any window, windows of channels beyond the configured count, and addresses whose two low bits are not 00. Reads of them return 0 and writes to them change nothing.
- R11: Read data appears on the read-data port one clock after the read request. Address bits above bit 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address (low 8 bits decoded) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| presc_tick | output | 1 | Prescaler tick shared by all channels |
| irq | output | NUM_TIMERS | One interrupt pulse line per channel |

## Verification
The bench reads the prescaler count on every cycle in a row. A design that reloaded one clock early or late would show a period of R or R+2 instead of R+1. A design that applied a new reload at once would cut the running period short. The bench times the first interrupt pulse after a load, so an off-by-one underflow (firing at the N-th tick instead of the (N+1)-th) lands on the wrong cycle. It also writes control words with and without bit 4, which catches a pending flag that clears on any write or never clears. It reads and writes an absent third channel, the +0xC holes, misaligned addresses and aliased upper address bits, which catches decode that wraps, ignores the byte-lane bits or lets stray writes corrupt neighbouring registers.

// File: rtl/ttu_pkg.sv
package ttu_pkg;

  localparam int unsigned PRE_W   = 16;
  localparam int unsigned BUS_W   = 32;

  // word index inside a 16-byte window
  localparam logic [1:0] W_COUNT  = 2'd0;
  localparam logic [1:0] W_RELOAD = 2'd1;
  localparam logic [1:0] W_CTRL   = 2'd2;

  // channel control bit positions
  localparam int unsigned CB_EN = 0;
  localparam int unsigned CB_RS = 1;
  localparam int unsigned CB_LD = 2;
  localparam int unsigned CB_IE = 3;
  localparam int unsigned CB_IP = 4;

  typedef struct packed {
    logic       hit;
    logic       unit;
    logic [2:0] chan;
    logic [1:0] word;
  } dec_t;

  // capability word: timers-1, base irq line, per-timer irq, freeze off
  function automatic logic [BUS_W-1:0] cap_word(int unsigned ntim, int unsigned irqb);
    logic [BUS_W-1:0] w;
    w       = '0;
    w[2:0]  = 3'(ntim - 1);
    w[7:3]  = 5'(irqb);
    w[8]    = 1'b1;
    w[9]    = 1'b1;
    return w;
  endfunction

  // next value of the prescaler count when no write is present
  function automatic logic [PRE_W-1:0] pre_next(logic [PRE_W-1:0] cur, logic [PRE_W-1:0] rld);
    return (cur == '0) ? rld : cur - 1'b1;
  endfunction

  // low-byte address decode
  function automatic dec_t decode_addr(logic [7:0] a, int unsigned ntim);
    dec_t       d;
    logic [3:0] win;
    d      = '0;
    win    = a[7:4];
    d.word = a[3:2];
    if (a[1:0] == 2'b00 && a[3:2] != 2'b11) begin
      if (win == 4'd0) begin
        d.hit  = 1'b1;
        d.unit = 1'b1;
      end else if (32'(win) <= ntim) begin
        d.hit  = 1'b1;
        d.chan = 3'(win - 4'd1);
      end
    end
    return d;
  endfunction

endpackage

// File: rtl/ttu_prescaler.sv
module ttu_prescaler
  import ttu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_count,
  input  logic             wr_reload,
  input  logic [PRE_W-1:0] wdata,
  output logic [PRE_W-1:0] count,
  output logic [PRE_W-1:0] reload,
  output logic             tick
);

  assign tick = (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      reload <= '0;
    end else begin
      if (wr_reload) reload <= wdata;
      if (wr_count)  count  <= wdata;
      else           count  <= pre_next(count, reload);
    end
  end

  a_r2_reload_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_count) |=> (count == $past(reload)));

  a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_count) |=> (count == $past(count) - 1'b1));

  a_r3_reload_no_truncate: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_reload && !tick && !wr_count) |=> (count == $past(count) - 1'b1));

endmodule

// File: rtl/ttu_channel.sv
module ttu_channel
  import ttu_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_count,
  input  logic             wr_reload,
  input  logic             wr_ctrl,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] reload,
  output logic [4:0]       ctrl,
  output logic             irq
);

  logic en, rs, ie, pend;
  logic uflow;

  assign uflow = tick && en && (count == '0);
  assign ctrl  = {pend, ie, 1'b0, rs, en};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      reload <= '0;
      en     <= 1'b0;
      rs     <= 1'b0;
      ie     <= 1'b0;
      pend   <= 1'b0;
      irq    <= 1'b0;
    end else begin
      irq <= uflow && ie;

      if (wr_reload) reload <= wdata;

      if (wr_count)                    count <= wdata;
      else if (wr_ctrl && wdata[CB_LD]) count <= reload;
      else if (tick && en) begin
        if (count == '0) begin
          if (rs) count <= reload;
        end else begin
          count <= count - 1'b1;
        end
      end

      if (wr_ctrl) begin
        en <= wdata[CB_EN];
        rs <= wdata[CB_RS];
        ie <= wdata[CB_IE];
      end else if (uflow && !rs) begin
        en <= 1'b0;
      end

      if (uflow && ie)                       pend <= 1'b1;
      else if (wr_ctrl && wdata[CB_IP])      pend <= 1'b0;
    end
  end

  a_r7_irq_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pend);

  a_r7_irq_from_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow && ie) |=> irq);

  a_r6_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_count && !wr_ctrl) |=> $stable(count));

  a_r8_stop_without_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow && !rs && !wr_ctrl) |=> (!en && count == '0));

  a_r9_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wdata[CB_LD] && !wr_count) |=> (count == $past(reload)));

endmodule

// File: rtl/ttu_decode.sv
module ttu_decode
  import ttu_pkg::*;
#(
  parameter int unsigned NUM_TIMERS = 2
) (
  input  logic [7:0]            addr,
  output dec_t                  dec,
  output logic [NUM_TIMERS-1:0] ch_sel
);

  assign dec = decode_addr(addr, NUM_TIMERS);

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_sel
    assign ch_sel[i] = dec.hit && !dec.unit && (dec.chan == 3'(i));
  end

endmodule

// File: rtl/ttu_top.sv
module ttu_top
  import ttu_pkg::*;
#(
  parameter int unsigned NUM_TIMERS = 2,
  parameter int unsigned IRQ_BASE   = 8,
  parameter int unsigned ADDR_W     = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_valid,
  input  logic                  bus_write,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [BUS_W-1:0]      bus_wdata,
  output logic [BUS_W-1:0]      bus_rdata,
  output logic                  presc_tick,
  output logic [NUM_TIMERS-1:0] irq
);

  localparam logic [BUS_W-1:0] CAP = cap_word(NUM_TIMERS, IRQ_BASE);

  dec_t                  dec;
  logic [NUM_TIMERS-1:0] ch_sel;
  logic                  wr_acc, rd_acc;
  logic [PRE_W-1:0]      pre_count, pre_reload;
  logic [BUS_W-1:0]      ch_count  [NUM_TIMERS];
  logic [BUS_W-1:0]      ch_reload [NUM_TIMERS];
  logic [4:0]            ch_ctrl   [NUM_TIMERS];
  logic [BUS_W-1:0]      rd_mux;

  if (ADDR_W > 8) begin : g_hi
    logic addr_hi_unused;
    assign addr_hi_unused = ^bus_addr[ADDR_W-1:8];
  end

  assign wr_acc = bus_valid &&  bus_write;
  assign rd_acc = bus_valid && !bus_write;

  ttu_decode #(.NUM_TIMERS(NUM_TIMERS)) u_dec (
    .addr   (bus_addr[7:0]),
    .dec    (dec),
    .ch_sel (ch_sel)
  );

  ttu_prescaler u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_count  (wr_acc && dec.hit && dec.unit && dec.word == W_COUNT),
    .wr_reload (wr_acc && dec.hit && dec.unit && dec.word == W_RELOAD),
    .wdata     (bus_wdata[PRE_W-1:0]),
    .count     (pre_count),
    .reload    (pre_reload),
    .tick      (presc_tick)
  );

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_ch
    ttu_channel #(.CNT_W(BUS_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (presc_tick),
      .wr_count  (wr_acc && ch_sel[i] && dec.word == W_COUNT),
      .wr_reload (wr_acc && ch_sel[i] && dec.word == W_RELOAD),
      .wr_ctrl   (wr_acc && ch_sel[i] && dec.word == W_CTRL),
      .wdata     (bus_wdata),
      .count     (ch_count[i]),
      .reload    (ch_reload[i]),
      .ctrl      (ch_ctrl[i]),
      .irq       (irq[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (dec.hit && dec.unit) begin
      case (dec.word)
        W_COUNT:  rd_mux = BUS_W'(pre_count);
        W_RELOAD: rd_mux = BUS_W'(pre_reload);
        W_CTRL:   rd_mux = CAP;
        default:  rd_mux = '0;
      endcase
    end else begin
      for (int i = 0; i < NUM_TIMERS; i++) begin
        if (ch_sel[i]) begin
          case (dec.word)
            W_COUNT:  rd_mux = ch_count[i];
            W_RELOAD: rd_mux = ch_reload[i];
            W_CTRL:   rd_mux = BUS_W'(ch_ctrl[i]);
            default:  rd_mux = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (rd_acc) bus_rdata <= rd_mux;
  end

  a_r10_single_channel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_sel));

  a_r10_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && !dec.hit) |=> (bus_rdata == '0));

  a_r4_cap_readonly: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && dec.hit && dec.unit && dec.word == W_CTRL) |=> (bus_rdata == CAP));

  a_r11_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> $stable(bus_rdata));

endmodule

// File: tb/ttu_top_tb_top.sv
module ttu_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        presc_tick;
  logic [1:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ttu_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .presc_tick(presc_tick), .irq(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h000, 32'h0, 32'h0, 4'd1},          // R1 prescaler count
    '{1'b0, 12'h004, 32'h0, 32'h0, 4'd1},          // R1 prescaler reload
    '{1'b0, 12'h010, 32'h0, 32'h0, 4'd1},          // R1 ch0 counter
    '{1'b0, 12'h014, 32'h0, 32'h0, 4'd1},          // R1 ch0 reload
    '{1'b0, 12'h018, 32'h0, 32'h0, 4'd1},          // R1 ch0 control
    '{1'b0, 12'h028, 32'h0, 32'h0, 4'd1},          // R1 ch1 control
    '{1'b0, 12'h008, 32'h0, 32'h341, 4'd4},        // R4 capability
    '{1'b1, 12'h008, 32'hFFFF_FFFF, 32'h0, 4'd4},
    '{1'b0, 12'h008, 32'h0, 32'h341, 4'd4},        // R4 write ignored
    '{1'b1, 12'h014, 32'h55, 32'h0, 4'd5},
    '{1'b0, 12'h014, 32'h0, 32'h55, 4'd5},         // R5 ch0 reload
    '{1'b1, 12'h024, 32'hAA, 32'h0, 4'd5},
    '{1'b0, 12'h024, 32'h0, 32'hAA, 4'd5},         // R5 ch1 reload
    '{1'b1, 12'h018, 32'h04, 32'h0, 4'd9},
    '{1'b0, 12'h010, 32'h0, 32'h55, 4'd9},         // R9 load copies reload
    '{1'b0, 12'h018, 32'h0, 32'h0, 4'd9},          // R9 load bit reads 0
    '{1'b1, 12'h034, 32'h77, 32'h0, 4'd10},
    '{1'b0, 12'h034, 32'h0, 32'h0, 4'd10},         // R10 absent channel
    '{1'b0, 12'h00C, 32'h0, 32'h0, 4'd10},         // R10 unit hole
    '{1'b0, 12'h01C, 32'h0, 32'h0, 4'd10},         // R10 channel hole
    '{1'b0, 12'h016, 32'h0, 32'h0, 4'd10},         // R10 misaligned read
    '{1'b1, 12'h025, 32'h99, 32'h0, 4'd10},
    '{1'b0, 12'h024, 32'h0, 32'hAA, 4'd10},        // R10 misaligned write
    '{1'b0, 12'h114, 32'h0, 32'h55, 4'd11},        // R11 upper bits alias
    '{1'b0, 12'h110, 32'h0, 32'h55, 4'd11}         // R11 upper bits alias
  };

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic bus_wr(logic [11:0] a, logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(logic [11:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  // back-to-back reads of one address, one expected value per cycle
  task automatic rd_stream(string req, logic [11:0] a, int n, logic [31:0] exp [8]);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check(req, bus_rdata, exp[k]);
    end
    bus_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] ex [8];
    repeat (3) @(negedge clk);
    check("R1 irq idle", 32'(irq), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      if (VECS[v].wr) bus_wr(VECS[v].addr, VECS[v].data);
      else begin
        bus_rd(VECS[v].addr, rd);
        check($sformatf("R%0d vec %0d", VECS[v].req, v), rd, VECS[v].exp);
      end
    end

    // R2: period of reload+1, observed one read per cycle
    bus_wr(12'h004, 32'd3);
    bus_wr(12'h000, 32'd3);
    ex = '{32'd3, 32'd2, 32'd1, 32'd0, 32'd3, 32'd2, 32'd0, 32'd0};
    rd_stream("R2 prescaler sequence", 12'h000, 6, ex);

    // R3: new reload waits for the running period to end
    bus_wr(12'h000, 32'd3);
    bus_wr(12'h004, 32'd7);
    ex = '{32'd2, 32'd1, 32'd0, 32'd7, 32'd6, 32'd0, 32'd0, 32'd0};
    rd_stream("R3 deferred reload", 12'h000, 5, ex);

    // R3: count write masked to 16 bits, R11 one-cycle latency
    bus_wr(12'h000, 32'hABCD_1234);
    bus_rd(12'h000, rd);
    check("R3 count mask", rd, 32'h1234);

    // tick every clock from here on
    bus_wr(12'h004, 32'd0);
    bus_wr(12'h000, 32'd0);
    check("R2 tick with reload 0", 32'(presc_tick), 32'd1);

    // R6/R7/R8: ch0 one-shot from 5
    bus_wr(12'h014, 32'd5);
    bus_wr(12'h018, 32'h0D);
    repeat (5) @(negedge clk);
    check("R6 no early underflow", 32'(irq), 32'h0);
    @(negedge clk);
    check("R6 R7 irq on sixth tick", 32'(irq), 32'h1);
    @(negedge clk);
    check("R7 single-cycle irq", 32'(irq), 32'h0);
    bus_rd(12'h018, rd);
    check("R8 one-shot stops, R7 pending", rd, 32'h18);
    bus_rd(12'h010, rd);
    check("R8 counter holds 0", rd, 32'h0);

    // R7: pending kept without bit 4, cleared with it
    bus_wr(12'h018, 32'h08);
    bus_rd(12'h018, rd);
    check("R7 pending kept", rd, 32'h18);
    bus_wr(12'h018, 32'h10);
    bus_rd(12'h018, rd);
    check("R7 pending cleared", rd, 32'h0);

    // R8: ch1 periodic from 2
    bus_wr(12'h024, 32'd2);
    bus_wr(12'h028, 32'h0F);
    repeat (3) @(negedge clk);
    check("R8 ch1 first underflow", 32'(irq), 32'h2);
    @(negedge clk);
    check("R8 ch1 gap", 32'(irq), 32'h0);
    repeat (2) @(negedge clk);
    check("R8 ch1 restarted underflow", 32'(irq), 32'h2);
    bus_wr(12'h028, 32'h00);
    bus_rd(12'h028, rd);
    check("R7 ch1 pending sticky", rd, 32'h10);
    bus_rd(12'h020, rd);
    check("R8 ch1 reloaded count", rd, 32'h1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule